// File: doc/BRIEF.md
# Parallel Memory Read Cycle Controller

This block is a clocked bus master that runs read cycles on an asynchronous parallel memory. The memory has an active-low chip select and an active-low output gate. A host hands in an address on a valid/ready request channel. The controller then drives the address and pulls chip select low. After a computed lag it pulls the output gate low. It waits until every access constraint has expired, captures the data word and releases the output gate. Before it lets anything drive the shared data bus again, it waits out the bus float time.

Each timing figure is given in picoseconds. Each wait is turned into a whole number of clock cycles when the design is elaborated: the time is divided by the clock period and rounded up, and one cycle of margin is added. The capture point is the latest of three counted windows:

- the address-to-data window, counted from the new address;
- the select-to-data window, counted from the chip-select fall;
- the gate-to-data window, counted from the output-gate fall.

With `KEEP_CE` set, chip select stays low through the float gap. A request accepted at the end of that gap therefore reuses the selected device. Chip select goes high whenever the controller falls back to idle.

The response channel is valid/ready. A captured word stays on `rsp_data` with `rsp_valid` high until the host takes it with `rsp_ready`. Only one read is in flight at a time: `req_ready` stays low while a response is unaccepted, which is the only back-pressure path.

Top module: `pmem_read_ctrl`

## Requirements
- R1: Out of reset, `mem_ce_n` and `mem_oe_n` are 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is taken on the clock edge where both `req_valid` and `req_ready` are 1. `req_ready` is 1 only when no response is pending and the controller is either idle or in the last cycle of its float gap.
- R3: `mem_addr` takes the request address on the accepting edge. It changes on no other edge, so it stays stable through the access and the float gap.
- R4: `mem_oe_n` falls LAG edges after the accepting edge, where LAG is the address wait minus the output-gate wait (3 at the defaults). `mem_oe_n` is 1 at every other time outside an access.
- R5: The data word is sampled on the edge at which the address, chip-select and output-gate windows have all expired. `rsp_data` then holds the value seen on `mem_dq` at that edge.
- R6: On the sampling edge `mem_oe_n` returns to 1.
- R7: After `mem_oe_n` rises, neither a new request nor a new output-gate fall happens for at least FLOAT cycles (5 at the defaults).
- R8: With `KEEP_CE`=1 (the default), `mem_ce_n` stays 0 through the float gap and stays 0 into a request accepted at its end. `mem_ce_n` is 1 in every idle cycle.
- R9: `rsp_valid` stays 1 and `rsp_data` stays unchanged until a cycle with `rsp_ready`=1. Every accepted request yields exactly one response.
- R10: Each wait in cycles is floor((t + period − 1) / period) + 1. At a 10 ns clock with 70/70/40/40 ns figures, `rsp_valid` first shows 8 cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | AW | Word address to read |
| rsp_valid | output | 1 | Captured word available |
| rsp_ready | input | 1 | Host takes the captured word |
| rsp_data | output | DW | Captured word |
| mem_addr | output | AW | Address to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output gate, active low |
| mem_dq | input | DW | Data bus from the memory |

## Verification
The bench's memory model drives a poison word on `mem_dq` until every access window has run out, measured from its own view of the address, select and gate edges. If a wait counter is mis-sized or started on the wrong edge, the wrong data shows up on `rsp_data` on the edge that raises `rsp_valid`. If the controller state goes wrong, `req_ready`, `mem_ce_n` or `mem_oe_n` depart from the cycle-exact reference on the very next clock. A short float gap is caught by a separate count of cycles between an output-gate rise and the next fall. A dropped or duplicated response shows as a mismatch between the request and response totals at the end of the run.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_ACCESS = 2'd1,
    RD_FLOAT  = 2'd2
  } rd_state_e;

  // Ceiling of time over period, plus one margin cycle.
  function automatic int wait_cycles(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps + 1;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rdc_timer.sv
module rdc_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // An expired window stays expired until reloaded (R5)
  assert_expired_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && done) |=> done);

endmodule

// File: rtl/rdc_resp.sv
module rdc_resp #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] din,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (cap) begin
      rsp_valid <= 1'b1;
      rsp_data  <= din;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

endmodule

// File: rtl/pmem_read_ctrl.sv
module pmem_read_ctrl
  import rdc_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int CLK_PS  = 10000,
  parameter int TACC_PS = 70000,
  parameter int TCE_PS  = 70000,
  parameter int TOE_PS  = 40000,
  parameter int TDF_PS  = 40000,
  parameter bit KEEP_CE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  input  logic [DW-1:0] mem_dq
);

  localparam int ACC_CYC = wait_cycles(TACC_PS, CLK_PS);
  localparam int CE_CYC  = wait_cycles(TCE_PS, CLK_PS);
  localparam int OE_CYC  = wait_cycles(TOE_PS, CLK_PS);
  localparam int DF_CYC  = wait_cycles(TDF_PS, CLK_PS);
  localparam int LONG_CYC = max2(ACC_CYC, CE_CYC);
  localparam int LAG     = (LONG_CYC > OE_CYC) ? LONG_CYC - OE_CYC : 0;
  localparam int MAXC    = max2(max2(LONG_CYC, OE_CYC), DF_CYC);
  localparam int TW      = $clog2(MAXC + 1);

  // Timer slots
  localparam int T_ADR = 0;
  localparam int T_CE  = 1;
  localparam int T_OE  = 2;
  localparam int T_LAG = 3;
  localparam int T_FLT = 4;
  localparam int NT    = 5;

  rd_state_e         state_q;
  logic [AW-1:0]     addr_q;
  logic              ce_n_q, oe_n_q;
  logic [NT-1:0]     t_load, t_done;
  logic [TW-1:0]     t_val [NT];
  logic              req_fire, oe_go, sample;

  assign req_ready = !rsp_valid &&
                     ((state_q == RD_IDLE) || ((state_q == RD_FLOAT) && t_done[T_FLT]));
  assign req_fire  = req_valid && req_ready;
  assign oe_go     = (state_q == RD_ACCESS) && oe_n_q && t_done[T_LAG];
  assign sample    = (state_q == RD_ACCESS) && !oe_n_q &&
                     t_done[T_ADR] && t_done[T_CE] && t_done[T_OE];

  always_comb begin
    t_load[T_ADR] = req_fire;
    t_val[T_ADR]  = TW'(ACC_CYC - 1);
    t_load[T_CE]  = req_fire;
    t_val[T_CE]   = ce_n_q ? TW'(CE_CYC - 1) : '0;
    t_load[T_LAG] = req_fire;
    t_val[T_LAG]  = (LAG > 0) ? TW'(LAG - 1) : '0;
    t_load[T_OE]  = oe_go || (req_fire && (LAG == 0));
    t_val[T_OE]   = TW'(OE_CYC - 1);
    t_load[T_FLT] = sample;
    t_val[T_FLT]  = TW'(DF_CYC - 1);
  end

  for (genvar gi = 0; gi < NT; gi++) begin : g_tmr
    rdc_timer #(.W(TW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load[gi]),
      .load_val (t_val[gi]),
      .done     (t_done[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      addr_q  <= '0;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
    end else if (req_fire) begin
      state_q <= RD_ACCESS;
      addr_q  <= req_addr;
      ce_n_q  <= 1'b0;
      oe_n_q  <= (LAG == 0) ? 1'b0 : 1'b1;
    end else if (oe_go) begin
      oe_n_q  <= 1'b0;
    end else if (sample) begin
      state_q <= RD_FLOAT;
      oe_n_q  <= 1'b1;
      ce_n_q  <= !KEEP_CE;
    end else if ((state_q == RD_FLOAT) && t_done[T_FLT]) begin
      state_q <= RD_IDLE;
      ce_n_q  <= 1'b1;
    end
  end

  rdc_resp #(.DW(DW)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (sample),
    .din       (mem_dq),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  assign mem_addr = addr_q;
  assign mem_ce_n = ce_n_q;
  assign mem_oe_n = oe_n_q;

  // Cycles since the output gate last rose, saturating at the float wait
  logic [TW-1:0] gap_q;
  logic          oe_prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= TW'(DF_CYC);
      oe_prev_q <= 1'b1;
    end else begin
      oe_prev_q <= oe_n_q;
      if (oe_n_q && !oe_prev_q)  gap_q <= TW'(1);
      else if (gap_q < TW'(DF_CYC)) gap_q <= gap_q + 1'b1;
    end
  end

  assert_float_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> (gap_q >= TW'(DF_CYC)));

  assert_gate_inside_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n);

  assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> $stable(mem_addr));

  assert_sample_bus_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> ($past(!mem_ce_n) && $past(!mem_oe_n) && mem_oe_n));

  assert_idle_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RD_IDLE) |-> mem_ce_n);

endmodule

// File: tb/sim_pmem_read_ctrl.sv
`timescale 1ns/1ps
module sim_pmem_read_ctrl;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int PER_PS = 10000;
  localparam int ACC = (70000 + PER_PS - 1) / PER_PS + 1;  // 8
  localparam int OEW = (40000 + PER_PS - 1) / PER_PS + 1;  // 5
  localparam int DF  = (40000 + PER_PS - 1) / PER_PS + 1;  // 5
  localparam int LAG = ACC - OEW;                          // 3
  localparam bit KEEP = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic rsp_ready = 1'b1;
  logic [DW-1:0] mem_dq = 16'hDEAD;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] mem_addr;

  always #5 clk = ~clk;

  pmem_read_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_dq(mem_dq)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_req = 0;
  int n_rsp = 0;
  bit done_run = 1'b0;

  function automatic logic [DW-1:0] dfun(input logic [AW-1:0] a);
    return {a[3:0], a[15:4]} ^ 16'h3C5A;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, got, exp);
    end
  endtask

  // Memory model: poison data until every window has run out
  int a_age = 100, c_age = 100, o_age = 100;
  logic [AW-1:0] seen_addr = '0;
  logic seen_ce = 1'b1, seen_oe = 1'b1;
  always @(negedge clk) begin
    if (mem_addr !== seen_addr) a_age = 1; else a_age++;
    if (!mem_ce_n && seen_ce)   c_age = 1; else c_age++;
    if (!mem_oe_n && seen_oe)   o_age = 1; else o_age++;
    seen_addr = mem_addr; seen_ce = mem_ce_n; seen_oe = mem_oe_n;
    if (!mem_ce_n && !mem_oe_n && a_age >= ACC && c_age >= ACC && o_age >= OEW)
      mem_dq = dfun(mem_addr);
    else
      mem_dq = 16'hDEAD;
  end

  // Behavioural reference: 0 idle, 1 access, 2 float
  int m_st = 0, m_t = 0, m_f = 0;
  logic [AW-1:0] m_addr = '0;
  bit m_rv = 1'b0;
  logic [DW-1:0] m_rd = '0;

  function automatic bit e_ready();
    return !m_rv && (m_st == 0 || (m_st == 2 && m_f >= DF - 1));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_t = 0; m_f = 0; m_addr = '0; m_rv = 0; m_rd = '0;
    end else begin
      automatic bit fire = req_valid && e_ready();
      if (m_rv && rsp_ready) m_rv = 0;
      if (m_st == 1) begin
        if (m_t == ACC - 1) begin
          m_rv = 1; m_rd = dfun(m_addr); m_st = 2; m_f = 0;
        end else m_t++;
      end else if (fire) begin
        m_st = 1; m_t = 0; m_addr = req_addr;
      end else if (m_st == 2) begin
        if (m_f >= DF - 1) m_st = 0; else m_f++;
      end
    end
  end

  // Per-cycle comparison and targeted timing checks
  int since_acc = 0;
  int since_oe_rise = 100;
  bit prev_rv = 1'b0, prev_oe = 1'b1;
  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      chk("R2 req_ready", req_ready, e_ready());
      chk("R3 mem_addr", mem_addr, m_addr);
      chk("R8 mem_ce_n", mem_ce_n, (m_st == 0) ? 1 : (m_st == 1 ? 0 : (KEEP ? 0 : 1)));
      chk("R4 mem_oe_n", mem_oe_n, !(m_st == 1 && m_t >= LAG));
      chk("R5 rsp_valid", rsp_valid, m_rv);
      if (m_rv) chk("R9 rsp_data", rsp_data, m_rd);
      if (rsp_valid && !prev_rv) begin
        chk("R10 capture latency", since_acc, ACC);
        chk("R6 gate released at capture", mem_oe_n, 1);
      end
      if (!mem_oe_n && prev_oe)
        chk("R7 float gap before gate fall", (since_oe_rise >= DF), 1);
      if (mem_oe_n && !prev_oe) since_oe_rise = 1; else since_oe_rise++;
      if (req_valid && req_ready) begin
        n_req++; since_acc = 0;
        if (since_oe_rise < DF) chk("R7 float gap before accept", 0, 1);
      end else since_acc++;
      if (rsp_valid && rsp_ready) n_rsp++;
      prev_rv = rsp_valid; prev_oe = mem_oe_n;
    end
  end

  // Back-pressure windows on the response channel
  always @(negedge clk) begin
    cyc++;
    rsp_ready = !((cyc >= 120 && cyc < 140) || (cyc >= 300 && cyc < 305));
  end

  task automatic do_req(input logic [AW-1:0] a, input int gap);
    if (gap > 0) begin
      req_valid = 1'b0;
      repeat (gap) @(negedge clk);
    end
    req_valid = 1'b1;
    req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 ce", mem_ce_n, 1);
    chk("R1 oe", mem_oe_n, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    do_req(16'h0000, 0);
    do_req(16'hFFFF, 3);
    do_req(16'h1234, 0);       // back-to-back, select kept low
    do_req(16'h8001, 0);
    do_req(16'h00FF, 0);
    do_req(16'hA5A5, 6);
    do_req(16'h5A5A, 0);
    do_req(16'h0F0F, 1);
    do_req(16'hF0F0, 0);
    do_req(16'h7FFE, 12);
    do_req(16'h0001, 0);
    do_req(16'hC3C3, 0);
    req_valid = 1'b0;
    repeat (40) @(negedge clk);
    chk("R9 response count", n_rsp, n_req);
    chk("R8 idle deselect", mem_ce_n, 1);
    done_run = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      done_run = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule